// File: doc/BRIEF.md
# Multiplier-Free Transposed FIR Filter

This block is a fully parallel finite impulse response filter built in the transposed structure. Every clock it can take one signed input sample. The sample goes to all taps at once. Each tap scales it by a fixed coefficient and adds the result into a chain of registered partial sums. The register at the head of the chain is the filter output. Every partial sum is registered, so the clock rate and the throughput do not depend on the number of taps.

The block has no multipliers. Each coefficient is fixed at elaboration as two power-of-two terms, and each term carries its own sign. A tap product is therefore two shifted copies of the sample, combined by one add or one subtract. The partial-sum width is derived from the sample width, the largest shift and the tap count, so no sum can wrap. The chain advances only on cycles that carry a valid sample. Idle cycles leave the filter state and the output unchanged.

Top module: `shiftadd_fir`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is applied, and afterwards until the first valid output, `out_valid` is 0 and `out_data` is 0. All partial sums clear to zero, so samples accepted before a reset add nothing to later outputs.
- R2: The coefficient of tap k is s_a·2^a + s_b·2^b. Here a and b are the 3-bit fields `SHIFT_A[3k+2:3k]` and `SHIFT_B[3k+2:3k]`, each from 0 to 7. The sign s_a is -1 when bit k of `NEG_A` is 1 and +1 when it is 0, and s_b is set by `NEG_B` the same way. An input sample of zero gives a zero product in every tap.
- R3: Each valid output equals the sum over k of c_k·x[n-k]. Here x[n] is the newest accepted sample, x[n-k] is the sample accepted k valid samples earlier, and a sample that does not exist counts as zero.
- R4: A sample presented with `in_valid` high at clock edge t is registered at t. Its output appears with `out_valid` high after edge t+1.
- R5: A cycle with `in_valid` low does not advance the chain. Two edges later `out_valid` is low and `out_data` keeps its previous value.
- R6: Valid samples on consecutive clocks produce valid outputs on consecutive clocks, with no stall at any tap count.
- R7: Full-scale inputs (-128 or +127 on every tap) with coefficients as large as ±256 give exact results in the `ACC_W`-bit two's-complement output. No partial sum overflows.
- R8: A single sample of value 1 followed by zeros gives outputs c_0, c_1, …, c_{N-1}, in that order, on successive valid cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_sample` as a new sample this cycle |
| in_sample | input | IN_W | Signed two's-complement input sample |
| out_valid | output | 1 | High for one cycle per filter result |
| out_data | output | ACC_W | Signed filter result, held between results |

## Verification
The assertions assume that `in_sample` is a known value whenever `in_valid` is high. They also assume that `ACC_W` keeps its derived default, because the no-overflow property depends on that width bounding the largest possible sum. The bench stays inside these limits. It drives a defined sample on every valid cycle, including a sweep of all 256 sample codes. It drives zero on idle cycles and never overrides the width. It chooses coefficients that reach both shift extremes and both sign combinations, so the overflow property is tested at the edge of the range it covers.

// File: rtl/sa_fir_pkg.sv
package sa_fir_pkg;

  // Width of one shift-amount field in the coefficient parameters.
  localparam int SA_SHW = 3;

  // One signed power-of-two term applied to a sample.
  function automatic int sa_term(input int x, input int sh, input bit neg);
    int t;
    t = x * (1 << sh);
    return neg ? -t : t;
  endfunction

  // Full tap product: two terms, one add.
  function automatic int sa_product(input int x, input int sh_a, input bit neg_a,
                                    input int sh_b, input bit neg_b);
    return sa_term(x, sh_a, neg_a) + sa_term(x, sh_b, neg_b);
  endfunction

  // Output width that keeps every partial sum in range.
  function automatic int sa_acc_width(input int in_w, input int shw, input int ntaps);
    return in_w + (1 << shw) + $clog2(ntaps) + 1;
  endfunction

endpackage

// File: rtl/sa_tap_product.sv
module sa_tap_product #(
  parameter int IN_W  = 8,
  parameter int ACC_W = 20,
  parameter int SH_A  = 0,
  parameter int SH_B  = 0,
  parameter bit NEG_A = 1'b0,
  parameter bit NEG_B = 1'b0
) (
  input  logic signed [IN_W-1:0]  sample,
  output logic signed [ACC_W-1:0] product
);
  import sa_fir_pkg::*;

  // Sign-extend, then one shift per term.
  logic signed [ACC_W-1:0] ext;
  logic signed [ACC_W-1:0] term_a;
  logic signed [ACC_W-1:0] term_b;

  assign ext    = ACC_W'(sample);
  assign term_a = ext <<< SH_A;
  assign term_b = ext <<< SH_B;

  // The sign pair selects one adder or subtractor form.
  generate
    if (!NEG_A && !NEG_B) begin : g_pp
      assign product = term_a + term_b;
    end else if (!NEG_A && NEG_B) begin : g_pn
      assign product = term_a - term_b;
    end else if (NEG_A && !NEG_B) begin : g_np
      assign product = term_b - term_a;
    end else begin : g_nn
      assign product = -(term_a + term_b);
    end
  endgenerate

endmodule

// File: rtl/sa_tap_stage.sv
module sa_tap_stage #(
  parameter int ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    advance,
  input  logic signed [ACC_W-1:0] product,
  input  logic signed [ACC_W-1:0] carry_in,
  output logic signed [ACC_W-1:0] sum_q,
  output logic                    wrap
);
  // One extra bit so that a wrap can be seen.
  logic signed [ACC_W:0] wide;

  assign wide = {product[ACC_W-1], product} + {carry_in[ACC_W-1], carry_in};
  assign wrap = wide[ACC_W] ^ wide[ACC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (advance) begin
      sum_q <= wide[ACC_W-1:0];
    end
  end

endmodule

// File: rtl/shiftadd_fir.sv
module shiftadd_fir #(
  parameter int                            NTAPS   = 8,
  parameter int                            IN_W    = 8,
  parameter logic [NTAPS*sa_fir_pkg::SA_SHW-1:0] SHIFT_A = {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
  parameter logic [NTAPS*sa_fir_pkg::SA_SHW-1:0] SHIFT_B = {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7},
  parameter logic [NTAPS-1:0]              NEG_A   = 8'b0000_0000,
  parameter logic [NTAPS-1:0]              NEG_B   = 8'b1010_1010,
  parameter int                            ACC_W   = sa_fir_pkg::sa_acc_width(IN_W, sa_fir_pkg::SA_SHW, NTAPS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_sample,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_data
);
  import sa_fir_pkg::*;

  localparam int SHW = SA_SHW;

  // Input register stage.
  logic                   ev_accept;
  logic signed [IN_W-1:0] ev_sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_accept <= 1'b0;
      ev_sample <= '0;
    end else begin
      ev_accept <= in_valid;
      ev_sample <= in_valid ? in_sample : '0;
    end
  end

  // Tap chain: index 0 is the output end.
  logic signed [ACC_W-1:0] prods [NTAPS];
  logic signed [ACC_W-1:0] sums  [NTAPS];
  logic [NTAPS-1:0]        ev_ovf;
  logic                    ev_prod_nz;

  generate
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      localparam int SA_K = int'(SHIFT_A[k*SHW +: SHW]);
      localparam int SB_K = int'(SHIFT_B[k*SHW +: SHW]);
      logic signed [ACC_W-1:0] carry;

      sa_tap_product #(
        .IN_W (IN_W),
        .ACC_W(ACC_W),
        .SH_A (SA_K),
        .SH_B (SB_K),
        .NEG_A(NEG_A[k]),
        .NEG_B(NEG_B[k])
      ) u_prod (
        .sample (ev_sample),
        .product(prods[k])
      );

      if (k == NTAPS - 1) begin : g_tail
        assign carry = '0;
      end else begin : g_link
        assign carry = sums[k+1];
      end

      sa_tap_stage #(
        .ACC_W(ACC_W)
      ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (ev_accept),
        .product (prods[k]),
        .carry_in(carry),
        .sum_q   (sums[k]),
        .wrap    (ev_ovf[k])
      );
    end
  endgenerate

  always_comb begin
    ev_prod_nz = 1'b0;
    for (int k = 0; k < NTAPS; k++) begin
      ev_prod_nz = ev_prod_nz | (|prods[k]);
    end
  end

  // Output valid follows the accepted-sample flag by one stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= ev_accept;
    end
  end

  assign out_data = sums[0];

endmodule

// File: rtl/sa_fir_checker.sv
module sa_fir_checker #(
  parameter int NTAPS = 8,
  parameter int IN_W  = 8,
  parameter int ACC_W = 20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic signed [ACC_W-1:0] out_data,
  input logic                    ev_accept,
  input logic signed [IN_W-1:0]  ev_sample,
  input logic [NTAPS-1:0]        ev_ovf,
  input logic                    ev_prod_nz
);

  AST_ACCEPT_AFTER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ev_accept); // R4

  AST_OUT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> out_valid); // R4

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && in_valid) |=> (out_valid && ev_accept)); // R6

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_accept |=> !out_valid); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_accept |=> $stable(out_data)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> (ev_ovf == '0)); // R7

  AST_ZERO_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && ev_sample == '0) |-> !ev_prod_nz); // R2

endmodule

bind shiftadd_fir sa_fir_checker #(
  .NTAPS(NTAPS),
  .IN_W (IN_W),
  .ACC_W(ACC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data),
  .ev_accept (ev_accept),
  .ev_sample (ev_sample),
  .ev_ovf    (ev_ovf),
  .ev_prod_nz(ev_prod_nz)
);

// File: tb/tb_shiftadd_fir.sv
module tb_shiftadd_fir;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int IW = 8;
  localparam int AW = IW + 8 + 3 + 1;

  // Coefficient fields, tap 7 first in each literal.
  // Decoded per tap 0..7: -256, 2, 6, 31, 127, 0, -80, 256
  localparam logic [23:0] P_SHA = {3'd7, 3'd6, 3'd2, 3'd7, 3'd0, 3'd3, 3'd0, 3'd7};
  localparam logic [23:0] P_SHB = {3'd7, 3'd4, 3'd2, 3'd0, 3'd5, 3'd1, 3'd0, 3'd7};
  localparam logic [7:0]  P_NA  = 8'b0110_1001;
  localparam logic [7:0]  P_NB  = 8'b0101_0101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [IW-1:0] in_sample = '0;
  logic out_valid;
  logic signed [AW-1:0] out_data;

  shiftadd_fir #(
    .NTAPS(NT), .IN_W(IW),
    .SHIFT_A(P_SHA), .SHIFT_B(P_SHB), .NEG_A(P_NA), .NEG_B(P_NB)
  ) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int coef [NT];
  int hist [NT];
  int held = 0;
  bit    pv [2];
  int    pd [2];
  string pt [2];

  // Coefficients restated by the R2 rule: sign bit 1 means negative.
  function automatic int field3(input logic [23:0] f, input int k);
    return int'(f[k*3 +: 3]);
  endfunction

  initial begin
    for (int k = 0; k < NT; k++) begin
      coef[k] = (P_NA[k] ? -1 : 1) * (2 ** field3(P_SHA, k))
              + (P_NB[k] ? -1 : 1) * (2 ** field3(P_SHB, k));
    end
  end

  task automatic clear_model();
    for (int k = 0; k < NT; k++) hist[k] = 0;
    held = 0;
    for (int i = 0; i < 2; i++) begin pv[i] = 1'b0; pd[i] = 0; pt[i] = "R1"; end
  endtask

  // Called at a falling edge: check what was driven two edges ago, then drive.
  task automatic step(input bit v, input int x, input string tag);
    int acc;
    int exp_d;
    exp_d = pv[1] ? pd[1] : held;
    n_vec++;
    if (out_valid !== pv[1] || int'(out_data) !== exp_d) begin
      n_bad++;
      $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
               pt[1], out_valid, int'(out_data), pv[1], exp_d);
    end
    held = exp_d;
    pv[1] = pv[0]; pd[1] = pd[0]; pt[1] = pt[0];
    acc = 0;
    if (v) begin
      for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      for (int k = 0; k < NT; k++) acc += coef[k] * hist[k];
    end
    pv[0] = v; pd[0] = acc; pt[0] = tag;
    in_valid  = v;
    in_sample = v ? IW'(x) : '0;
    @(negedge clk);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < NT + 3; i++) step(1'b0, 0, tag);
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    in_sample = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      n_bad++;
      $display("FAIL R1: valid=%0b data=%0d expected valid=0 data=0",
               out_valid, int'(out_data));
    end
    rst_n = 1'b1;
    clear_model();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int lfsr;
    clear_model();
    @(negedge clk);
    do_reset();
    // R1: idle after reset, outputs remain zero
    for (int i = 0; i < 3; i++) step(1'b0, 0, "R1");
    // R8: impulse response reproduces coefficients in tap order
    step(1'b1, 1, "R8");
    for (int i = 0; i < NT; i++) step(1'b1, 0, "R8");
    drain("R8");
    // R3/R6: every sample code back to back
    for (int s = -128; s < 128; s++) step(1'b1, s, "R3_R6");
    drain("R3");
    // R7: full-scale runs against coefficients of magnitude 256
    for (int i = 0; i < 16; i++) step(1'b1, -128, "R7");
    for (int i = 0; i < 16; i++) step(1'b1, 127, "R7");
    for (int i = 0; i < 8; i++) step(1'b1, (i % 2) ? 127 : -128, "R7");
    drain("R7");
    // R5: irregular valid pattern, idle cycles must hold output
    lfsr = 8'hA5;
    for (int i = 0; i < 200; i++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 8'hFF;
      step(lfsr[0], lfsr - 128, "R5");
    end
    drain("R5");
    // R1: reset in mid-stream discards prior samples
    for (int i = 0; i < 6; i++) step(1'b1, 50 + i, "R3");
    do_reset();
    step(1'b1, 5, "R1");
    step(1'b1, 0, "R1");
    step(1'b1, 0, "R1");
    drain("R1");
    // R4: isolated samples with exact two-edge latency
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 3 - 20 * i, "R4");
      step(1'b0, 0, "R4");
      step(1'b0, 0, "R4");
    end
    drain("R4");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule